// File: doc/BRIEF.md
# 100BASE-X Receive Symbol Aligner and Nibble Decoder

This block sits between a line-side clock-recovery stage and the MII receive port of a fast Ethernet PHY. Every 40 ns clock it takes one 5-bit group of recovered code bits. The groups have no fixed relation to symbol boundaries. When scrambling is in use, the block removes the stream cipher first. It then finds the symbol boundary from the start delimiter and turns each 4B/5B code into a nibble. It drives the receive nibble, data-valid and error lines toward the MAC, plus a receive-activity flag for the carrier and collision logic.

The cipher uses an 11-bit recurrence. Each cipher bit equals the bit eleven places earlier XOR the bit nine places earlier. While the cipher is not yet locked, the block re-seeds it on every group from the complement of the last eleven received bits. This works because idle is all ones. A run of idle symbols therefore brings the cipher into step by itself. The block declares lock once a run of consecutive all-ones symbols has been seen. Only a locked receiver looks for a frame. A line fault drops both the frame and the lock.

Top module: `rxdec_top`

## Requirements
- R1: During and directly after reset, `rx_dv`, `rx_er`, `receiving` are low and `rxd` is 0000.
- R2: Code bits leave each 5-bit group most significant bit first. With `scr_bypass` low, each bit is XORed with a cipher bit c[n] = c[n-11] XOR c[n-9]. With `scr_bypass` high, received bits are used unchanged, so a scrambled stream is not recognised.
- R3: No frame is recognised until 13 consecutive all-ones (11111) symbols have been seen after descrambling. Before that point, the cipher state is re-seeded on every group from the complemented last 11 received bits.
- R4: While hunting, the start pair J=11000 then K=10001 is found at any of the five bit offsets relative to the input groups. That offset then fixes symbol alignment for the frame.
- R5: J and K are each delivered as nibble 0101 with `rx_dv` high and `rx_er` low. The first `rx_dv` nibble of a frame is always 0101.
- R6: Data codes decode to nibbles with `rx_er` low: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R7: A T symbol (01101) ends the frame. `rx_dv` is low from the T slot onward, and T and R (00111) yield no nibble. Whenever `rx_dv` is low, `rxd` is 0000.
- R8: Inside a frame, any other code (including J, K, H=00100 or 00000) is delivered with `rx_er` high, `rx_dv` high and `rxd` 0000.
- R9: Inside a frame, the first IDLE is delivered as an error nibble (`rx_er` high, `rxd` 0000). A second consecutive IDLE ends the frame with no nibble.
- R10: `link_fail` high forces `rx_dv` low at the next clock and clears cipher lock. A fresh 13-idle run is then needed before any frame.
- R11: `receiving` is high in exactly the cycles in which `rx_dv` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_in | input | 5 | Received code bits, bit 4 earliest |
| link_fail | input | 1 | Line fault; aborts frame and drops lock |
| scr_bypass | input | 1 | High: skip descrambling |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive coding error |
| receiving | output | 1 | Frame in progress |

## Verification
The bench builds the block with the default idle run of 13 and the 11-bit cipher with taps at 11 and 9. With these values the bench generates its own reference cipher from an arbitrary seed and checks lock after a realistic idle preamble. A preamble shorter than 13 idles gives the negative lock case. Every one of the five bit offsets is reachable by prefixing the stream with zero to four extra one-bits. Because the run length is 13, a stream that mixes data with trailing idles can be shown not to relock after a line fault.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    localparam logic [SYM_W-1:0] CODE_J    = 5'b11000;
    localparam logic [SYM_W-1:0] CODE_K    = 5'b10001;
    localparam logic [SYM_W-1:0] CODE_T    = 5'b01101;
    localparam logic [SYM_W-1:0] CODE_IDLE = 5'b11111;
    localparam logic [NIB_W-1:0] NIB_SSD   = 4'b0101;

    typedef enum logic [1:0] {
        FR_HUNT,
        FR_SSD2,
        FR_DATA,
        FR_IDLE1
    } fr_state_e;

    // {valid, nibble}
    function automatic logic [NIB_W:0] code_to_nib(input logic [SYM_W-1:0] c);
        logic [NIB_W:0] r;
        case (c)
            5'b11110: r = 5'h10;
            5'b01001: r = 5'h11;
            5'b10100: r = 5'h12;
            5'b10101: r = 5'h13;
            5'b01010: r = 5'h14;
            5'b01011: r = 5'h15;
            5'b01110: r = 5'h16;
            5'b01111: r = 5'h17;
            5'b10010: r = 5'h18;
            5'b10011: r = 5'h19;
            5'b10110: r = 5'h1A;
            5'b10111: r = 5'h1B;
            5'b11010: r = 5'h1C;
            5'b11011: r = 5'h1D;
            5'b11100: r = 5'h1E;
            5'b11101: r = 5'h1F;
            default:  r = 5'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxdec_descrambler.sv
module rxdec_descrambler #(
    parameter int SYM_W    = 5,
    parameter int LFSR_W   = 11,
    parameter int TAP_A    = 11,
    parameter int TAP_B    = 9,
    parameter int IDLE_RUN = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] raw_i,
    input  logic             bypass_i,
    input  logic             link_fail_i,
    output logic [SYM_W-1:0] desc_o,
    output logic             locked_o
);

    localparam int CNT_W = $clog2(IDLE_RUN + 1);

    typedef struct packed {
        logic [SYM_W-1:0]  raw;
        logic [LFSR_W-1:0] lfsr;
        logic [LFSR_W-1:0] hist;
        logic [CNT_W-1:0]  cnt;
        logic              locked;
    } ds_t;

    ds_t ds_d, ds_q;
    logic [SYM_W-1:0] key;
    logic             idle_now;

    always_comb begin
        logic [LFSR_W-1:0] s;
        ds_d     = ds_q;
        s        = ds_q.lfsr;
        key      = '0;
        for (int i = 0; i < SYM_W; i++) begin
            key[SYM_W-1-i] = s[TAP_A-1] ^ s[TAP_B-1];
            s = {s[LFSR_W-2:0], key[SYM_W-1-i]};
        end
        desc_o   = bypass_i ? ds_q.raw : (ds_q.raw ^ key);
        idle_now = &desc_o;

        ds_d.raw  = raw_i;
        ds_d.hist = {ds_q.hist[LFSR_W-SYM_W-1:0], ds_q.raw};

        if (link_fail_i) begin
            ds_d.lfsr   = ~ds_d.hist;
            ds_d.cnt    = '0;
            ds_d.locked = 1'b0;
        end else if (!ds_q.locked) begin
            ds_d.lfsr   = ~ds_d.hist;
            ds_d.cnt    = idle_now ? ds_q.cnt + 1'b1 : '0;
            ds_d.locked = idle_now && (ds_q.cnt == CNT_W'(IDLE_RUN - 1));
        end else begin
            ds_d.lfsr   = s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q.raw    <= '1;
            ds_q.lfsr   <= '1;
            ds_q.hist   <= '0;
            ds_q.cnt    <= '0;
            ds_q.locked <= 1'b0;
        end else begin
            ds_q <= ds_d;
        end
    end

    assign locked_o = ds_q.locked;

    // R3
    lock_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_q.locked) |-> $past(ds_q.cnt) == CNT_W'(IDLE_RUN - 1));

    // R10
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail_i |=> !ds_q.locked);

endmodule

// File: rtl/rxdec_framer.sv
module rxdec_framer
    import rxdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] desc_i,
    input  logic             locked_i,
    input  logic             link_fail_i,
    output logic [NIB_W-1:0] rxd_o,
    output logic             dv_o,
    output logic             er_o,
    output logic             recv_o
);

    localparam int WIN_W = 3 * SYM_W;
    localparam int OFF_W = $clog2(SYM_W);

    typedef struct packed {
        fr_state_e          st;
        logic [2*SYM_W-1:0] win;
        logic [OFF_W-1:0]   off;
        logic [NIB_W-1:0]   rxd;
        logic               dv;
        logic               er;
    } fr_t;

    fr_t fr_d, fr_q;
    logic [WIN_W-1:0] full;
    logic [SYM_W-1:0] aligned;
    logic             hit;
    logic [OFF_W-1:0] hit_off;
    logic [NIB_W:0]   dec;

    always_comb begin
        full    = {fr_q.win, desc_i};
        aligned = full[WIN_W-1-int'(fr_q.off) -: SYM_W];
        dec     = code_to_nib(aligned);
        hit     = 1'b0;
        hit_off = '0;
        for (int o = 0; o < SYM_W; o++) begin
            if (!hit && full[WIN_W-1-o -: 2*SYM_W] == {CODE_J, CODE_K}) begin
                hit     = 1'b1;
                hit_off = OFF_W'(o);
            end
        end

        fr_d     = fr_q;
        fr_d.win = {fr_q.win[SYM_W-1:0], desc_i};
        fr_d.rxd = '0;
        fr_d.dv  = 1'b0;
        fr_d.er  = 1'b0;

        case (fr_q.st)
            FR_HUNT: begin
                if (locked_i && hit) begin
                    fr_d.st  = FR_SSD2;
                    fr_d.off = hit_off;
                    fr_d.rxd = NIB_SSD;
                    fr_d.dv  = 1'b1;
                end
            end
            FR_SSD2: begin
                fr_d.st  = FR_DATA;
                fr_d.rxd = NIB_SSD;
                fr_d.dv  = 1'b1;
            end
            default: begin
                if (aligned == CODE_T) begin
                    fr_d.st = FR_HUNT;
                end else if (aligned == CODE_IDLE) begin
                    if (fr_q.st == FR_IDLE1) begin
                        fr_d.st = FR_HUNT;
                    end else begin
                        fr_d.st = FR_IDLE1;
                        fr_d.dv = 1'b1;
                        fr_d.er = 1'b1;
                    end
                end else begin
                    fr_d.st  = FR_DATA;
                    fr_d.dv  = 1'b1;
                    fr_d.er  = !dec[NIB_W];
                    fr_d.rxd = dec[NIB_W] ? dec[NIB_W-1:0] : '0;
                end
            end
        endcase

        if (link_fail_i) begin
            fr_d.st  = FR_HUNT;
            fr_d.rxd = '0;
            fr_d.dv  = 1'b0;
            fr_d.er  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q.st  <= FR_HUNT;
            fr_q.win <= '1;
            fr_q.off <= '0;
            fr_q.rxd <= '0;
            fr_q.dv  <= 1'b0;
            fr_q.er  <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign rxd_o  = fr_q.rxd;
    assign dv_o   = fr_q.dv;
    assign er_o   = fr_q.er;
    assign recv_o = (fr_q.st != FR_HUNT);

    // R5
    ssd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.dv) |-> (fr_q.rxd == NIB_SSD) && $past(locked_i));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail_i |=> !fr_q.dv);

    // R8
    er_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.er |-> fr_q.dv && (fr_q.rxd == '0));

    // R7
    quiet_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_q.dv |-> fr_q.rxd == '0);

endmodule

// File: rtl/rxdec_top.sv
module rxdec_top #(
    parameter int LFSR_W   = 11,
    parameter int TAP_A    = 11,
    parameter int TAP_B    = 9,
    parameter int IDLE_RUN = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] sym_in,
    input  logic       link_fail,
    input  logic       scr_bypass,
    output logic [3:0] rxd,
    output logic       rx_dv,
    output logic       rx_er,
    output logic       receiving
);

    logic [rxdec_pkg::SYM_W-1:0] desc;
    logic                        locked;

    rxdec_descrambler #(
        .SYM_W   (rxdec_pkg::SYM_W),
        .LFSR_W  (LFSR_W),
        .TAP_A   (TAP_A),
        .TAP_B   (TAP_B),
        .IDLE_RUN(IDLE_RUN)
    ) u_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (sym_in),
        .bypass_i   (scr_bypass),
        .link_fail_i(link_fail),
        .desc_o     (desc),
        .locked_o   (locked)
    );

    rxdec_framer u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_i     (desc),
        .locked_i   (locked),
        .link_fail_i(link_fail),
        .rxd_o      (rxd),
        .dv_o       (rx_dv),
        .er_o       (rx_er),
        .recv_o     (receiving)
    );

    // R11
    recv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        receiving == rx_dv);

endmodule

// File: tb/sim_rxdec_top.sv
module sim_rxdec_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] sym_in;
    logic       link_fail;
    logic       scr_bypass;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, receiving;

    always #10 clk = ~clk;

    rxdec_top u0 (
        .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .link_fail(link_fail),
        .scr_bypass(scr_bypass), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .receiving(receiving)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit bq[$];
    int exq[$];
    int gotq[$];
    int recv_bad, quiet_bad, after_lf;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] enc(input int n);
        case (n)
            0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
            4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
            8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
           12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    function automatic void put_sym(input logic [4:0] s);
        for (int i = 4; i >= 0; i--) bq.push_back(s[i]);
    endfunction

    function automatic void put_idles(input int n);
        for (int i = 0; i < n; i++) put_sym(5'b11111);
    endfunction

    function automatic void put_ssd();
        put_sym(5'b11000);
        put_sym(5'b10001);
        exq.push_back(5);
        exq.push_back(5);
    endfunction

    function automatic void put_end();
        put_sym(5'b01101);
        put_sym(5'b00111);
        put_idles(8);
    endfunction

    function automatic void pad_and_scramble(input bit scr, input logic [10:0] seed);
        logic [10:0] s;
        logic nb;
        while (bq.size() % 5 != 0) bq.push_back(1'b1);
        if (scr) begin
            s = seed;
            for (int i = 0; i < bq.size(); i++) begin
                nb = s[10] ^ s[8];
                s = {s[9:0], nb};
                bq[i] = bq[i] ^ nb;
            end
        end
    endfunction

    task automatic start_test(input bit bypass);
        @(negedge clk);
        link_fail = 1'b1;
        scr_bypass = bypass;
        sym_in = 5'b11111;
        @(negedge clk);
        link_fail = 1'b0;
        bq.delete(); exq.delete(); gotq.delete();
        recv_bad = 0; quiet_bad = 0; after_lf = 0;
    endtask

    task automatic play(input int lf_at);
        bit lf_seen = 0;
        for (int g = 0; g < bq.size() / 5; g++) begin
            @(negedge clk);
            if (rx_dv) gotq.push_back({27'd0, rx_er, rxd});
            if (receiving != rx_dv) recv_bad++;
            if (!rx_dv && rxd != 4'd0) quiet_bad++;
            if (lf_seen && g > lf_at + 1 && rx_dv) after_lf++;
            if (g == lf_at) begin
                chk(rx_dv == 1'b1, "R10 frame active before fault", int'(rx_dv), 1);
                link_fail = 1'b1;
                lf_seen = 1;
            end else if (lf_seen && g == lf_at + 1) begin
                chk(rx_dv == 1'b0, "R10 dv low after fault", int'(rx_dv), 0);
                link_fail = 1'b0;
            end
            for (int b = 0; b < 5; b++) sym_in[4-b] = bq[g*5+b];
        end
    endtask

    task automatic compare(input string tag);
        chk(gotq.size() == exq.size(), {tag, " nibble count"}, gotq.size(), exq.size());
        for (int i = 0; i < gotq.size() && i < exq.size(); i++)
            chk(gotq[i] == exq[i], {tag, " nibble"}, gotq[i], exq[i]);
        chk(recv_bad == 0, "R11 receiving vs rx_dv", recv_bad, 0);
        chk(quiet_bad == 0, "R7 rxd zero while not valid", quiet_bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; link_fail = 1'b0; scr_bypass = 1'b1; sym_in = 5'b11111;
        repeat (3) @(negedge clk);
        chk(rx_dv == 1'b0, "R1 dv in reset", int'(rx_dv), 0);
        chk(rx_er == 1'b0, "R1 er in reset", int'(rx_er), 0);
        chk(receiving == 1'b0, "R1 receiving in reset", int'(receiving), 0);
        chk(rxd == 4'd0, "R1 rxd in reset", int'(rxd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_dv == 1'b0 && rxd == 4'd0, "R1 after reset", int'(rx_dv), 0);
    endtask

    // R4 R5 R6 R7, and R2 when scr is set
    task automatic t_frame(input int k, input bit scr, input string tag);
        start_test(!scr);
        for (int i = 0; i < k; i++) bq.push_back(1'b1);
        put_idles(scr ? 20 : 14);
        put_ssd();
        for (int n = 0; n < 16; n++) begin
            put_sym(enc(n));
            exq.push_back(n);
        end
        put_sym(enc(6)); exq.push_back(6);
        put_end();
        pad_and_scramble(scr, 11'h5A3 + 11'(k));
        play(-1);
        compare(tag);
    endtask

    // R3: too few idles
    task automatic t_nolock();
        start_test(1'b1);
        put_idles(5);
        put_sym(5'b11000); put_sym(5'b10001);
        for (int n = 0; n < 6; n++) put_sym(enc(n));
        put_end();
        pad_and_scramble(1'b0, 11'h0);
        play(-1);
        compare("R3 short idle run");
    endtask

    // R2: scrambled line with bypass set
    task automatic t_bypass_scrambled();
        start_test(1'b1);
        put_idles(20);
        put_sym(5'b11000); put_sym(5'b10001);
        for (int n = 0; n < 6; n++) put_sym(enc(n));
        put_end();
        pad_and_scramble(1'b1, 11'h2C7);
        play(-1);
        compare("R2 bypass keeps cipher");
    endtask

    // R8
    task automatic t_invalid();
        start_test(1'b1);
        put_idles(14);
        put_ssd();
        put_sym(enc(1)); exq.push_back(1);
        put_sym(enc(2)); exq.push_back(2);
        put_sym(5'b00000); exq.push_back(16);
        put_sym(5'b00100); exq.push_back(16);
        put_sym(5'b10001); exq.push_back(16);
        put_sym(enc(3)); exq.push_back(3);
        put_end();
        pad_and_scramble(1'b0, 11'h0);
        play(-1);
        compare("R8 invalid codes");
    endtask

    // R9
    task automatic t_early_end();
        start_test(1'b1);
        put_idles(14);
        put_ssd();
        put_sym(enc(7)); exq.push_back(7);
        put_sym(enc(8)); exq.push_back(8);
        put_idles(2); exq.push_back(16);
        put_sym(enc(9));
        put_idles(8);
        pad_and_scramble(1'b0, 11'h0);
        play(-1);
        compare("R9 two idles end frame");
    endtask

    // R10
    task automatic t_link_fail();
        start_test(1'b1);
        put_idles(14);
        put_sym(5'b11000); put_sym(5'b10001);
        for (int n = 0; n < 20; n++) put_sym(enc(n % 16));
        put_end();
        pad_and_scramble(1'b0, 11'h0);
        play(24);
        chk(after_lf == 0, "R10 no frame after fault without new idle run", after_lf, 0);
        chk(recv_bad == 0, "R11 receiving vs rx_dv", recv_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        for (int k = 0; k < 5; k++) t_frame(k, 1'b0, "R4 R6 offset");
        t_frame(0, 1'b1, "R2 scrambled");
        t_frame(3, 1'b1, "R2 scrambled offset");
        t_nolock();
        t_bypass_scrambled();
        t_invalid();
        t_early_end();
        t_link_fail();
        t_frame(2, 1'b0, "R10 relock after fault");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule